// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes characters from a smart card over one shared, open-drain data line in half-duplex fashion. A single counter ticks once per internal clock. The bit period is a fixed number of those clocks (372 by default). The receiver watches for a falling edge and confirms the start bit half a bit later. It then samples eight data bits, least-significant first, and an even-parity bit, each at the centre of its bit period.

A character whose parity holds is written to the receive data register and raises the data-ready flag. The line stays released for the rest of the frame. A character whose parity fails does not touch the data register or the data-ready flag. Instead it sets the parity-error flag and, half a bit after the parity bit ends, pulls the line low for a programmable number of bit periods. This error pulse asks the card to repeat the character. Software clears the flags with one-cycle clear strobes. Two level interrupts report each flag when the receive-interrupt enable is set.

The controller has six named states:

- IDLE: waits for a falling edge.
- START: goes to DATA when the line is low at half a bit, and back to IDLE when it is high.
- DATA: goes to PARITY after the last data sample.
- PARITY: goes to GAP at the parity sample.
- GAP: goes to SIGNAL after one bit.
- SIGNAL: drives the line only after a failed parity check, then returns to IDLE.

Top module: `sc_char_rx`

## Requirements
- R1: After reset `line_oe`, `rdy_flag`, `perr_flag`, `irq_rx` and `irq_err` are 0, and `rx_data` is 0x00.
- R2: A start is accepted only if the line is still low 186 cycles after the edge at which the low level is first seen. A low pulse that has ended by then returns the receiver to IDLE with no flag set and no drive on the line.
- R3: The bits are sampled every 372 cycles after the start sample. The first data bit is `rx_data[0]` and the eighth is `rx_data[7]`.
- R4: When the ones in the eight data bits plus the parity bit add up to an even count, `rx_data` takes the received byte and `rdy_flag` becomes 1. `perr_flag` is left unchanged.
- R5: When that count is odd, `perr_flag` becomes 1. Both `rdy_flag` and `rx_data` keep their previous values.
- R6: After a parity failure, `line_oe` goes to 1 at the clock edge 3906 cycles (10.5 bit periods) after the edge at which the start low was first seen. It stays at 1 for exactly ERR_ETUS × 372 cycles (372 by default).
- R7: For a character with good parity, `line_oe` stays 0 for the whole frame, including the error-signal interval.
- R8: `irq_rx` is 1 exactly when `rdy_flag` and `rx_int_en` are both 1. `irq_err` is 1 exactly when `perr_flag` and `rx_int_en` are both 1.
- R9: A one-cycle pulse on `rdy_clr` (or on `perr_clr`) clears its flag at the next edge. A flag changes from 1 to 0 only through its own clear strobe.
- R10: Once the error-signal interval ends, the receiver is back in IDLE and takes the next character normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, a fixed multiple of the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level sensed on the shared data line |
| line_oe | output | 1 | 1 pulls the shared line low (open drain) |
| rx_int_en | input | 1 | Receive-interrupt enable |
| rdy_clr | input | 1 | One-cycle strobe that clears the data-ready flag |
| perr_clr | input | 1 | One-cycle strobe that clears the parity-error flag |
| rx_data | output | 8 | Last character received with good parity |
| rdy_flag | output | 1 | Data-ready flag |
| perr_flag | output | 1 | Parity-error flag |
| irq_rx | output | 1 | Receive interrupt (level) |
| irq_err | output | 1 | Error interrupt (level) |

## Verification
A bit counter or sample point that is off by one shows up within one frame, in three ways: the byte is shifted, the parity decision is wrong, or the error pulse starts at the wrong edge. The bench measures the pulse onset to the exact cycle and its length to the exact count. A state machine stuck after the guard interval is exposed by the next character, which then never raises a flag. Flag handling is checked at the ports right after each frame: data and flags must stay untouched on a failed or spurious start.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_GAP,
        ST_SIGNAL
    } rx_state_e;
endpackage

// File: rtl/sc_etu_timer.sv
// Period counter: restarts while held, pulses 'expire' on the last cycle of each period of 'len' cycles.
module sc_etu_timer #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] len,
    output logic          expire
);
    logic [TW-1:0] cnt;

    assign expire = (cnt == len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (expire)  cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sc_rx_shift.sv
// LSB-first deserializer with a running XOR of the bits shifted in.
module sc_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         odd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            odd  <= 1'b0;
        end else if (clear) begin
            word <= '0;
            odd  <= 1'b0;
        end else if (shift_en) begin
            word <= {bit_in, word[W-1:1]};
            odd  <= odd ^ bit_in;
        end
    end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int ETU_CYCLES = 372,
    parameter int DATA_BITS  = 8,
    parameter int ERR_ETUS   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    output logic                 line_oe,
    input  logic                 rx_int_en,
    input  logic                 rdy_clr,
    input  logic                 perr_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rdy_flag,
    output logic                 perr_flag,
    output logic                 irq_rx,
    output logic                 irq_err
);
    localparam int HALF    = ETU_CYCLES / 2;
    localparam int SIG_LEN = ETU_CYCLES * ERR_ETUS;
    localparam int TW      = $clog2(SIG_LEN + 1);
    localparam int BW      = $clog2(DATA_BITS);

    rx_state_e             state, state_nx;
    logic                  line_prev;
    logic [BW-1:0]         bit_idx;
    logic                  bad_q;
    logic [TW-1:0]         tlen;
    logic                  expire;
    logic [DATA_BITS-1:0]  word;
    logic                  odd;
    logic                  par_sample, par_ok, shift_en;

    // Period selection per state
    always_comb begin
        unique case (state)
            ST_START:  tlen = TW'(HALF);
            ST_SIGNAL: tlen = TW'(SIG_LEN);
            default:   tlen = TW'(ETU_CYCLES);
        endcase
    end

    sc_etu_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == ST_IDLE),
        .len     (tlen),
        .expire  (expire)
    );

    assign shift_en = (state == ST_DATA) && expire;

    sc_rx_shift #(.W(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_IDLE),
        .shift_en (shift_en),
        .bit_in   (line_in),
        .word     (word),
        .odd      (odd)
    );

    assign par_sample = (state == ST_PARITY) && expire;
    assign par_ok     = ~(odd ^ line_in);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (line_prev && !line_in) state_nx = ST_START;
            ST_START:  if (expire) state_nx = line_in ? ST_IDLE : ST_DATA;
            ST_DATA:   if (expire && bit_idx == BW'(DATA_BITS - 1)) state_nx = ST_PARITY;
            ST_PARITY: if (expire) state_nx = ST_GAP;
            ST_GAP:    if (expire) state_nx = ST_SIGNAL;
            ST_SIGNAL: if (expire) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_prev <= 1'b1;
            bit_idx   <= '0;
            bad_q     <= 1'b0;
            rx_data   <= '0;
            rdy_flag  <= 1'b0;
            perr_flag <= 1'b0;
        end else begin
            line_prev <= line_in;
            if (state == ST_IDLE)  bit_idx <= '0;
            else if (shift_en)     bit_idx <= bit_idx + 1'b1;
            if (par_sample) begin
                bad_q <= ~par_ok;
                if (par_ok) rx_data <= word;
            end
            rdy_flag  <= (par_sample && par_ok)  || (rdy_flag  && !rdy_clr);
            perr_flag <= (par_sample && !par_ok) || (perr_flag && !perr_clr);
        end
    end

    assign line_oe = (state == ST_SIGNAL) && bad_q;
    assign irq_rx  = rdy_flag  && rx_int_en;
    assign irq_err = perr_flag && rx_int_en;
endmodule

// File: rtl/sc_rx_checker.sv
module sc_rx_checker #(
    parameter int SIG_LEN = 372,
    parameter int DW      = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_oe,
    input logic          rdy_flag,
    input logic          perr_flag,
    input logic          rdy_clr,
    input logic          perr_clr,
    input logic [DW-1:0] rx_data
);
    localparam int RW = $clog2(SIG_LEN + 2);
    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run <= '0;
        else if (line_oe) run <= run + 1'b1;
        else              run <= '0;
    end

    assert_oe_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(SIG_LEN));

    assert_oe_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> run == RW'(SIG_LEN));

    assert_data_only_with_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(rdy_flag));

    assert_no_ready_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_flag) |-> !$rose(rdy_flag));

    assert_ready_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_flag) |-> $past(rdy_clr));

    assert_perr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_flag) |-> $past(perr_clr));

    assert_no_drive_at_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_flag) |-> !line_oe);
endmodule

bind sc_char_rx sc_rx_checker #(.SIG_LEN(ETU_CYCLES * ERR_ETUS), .DW(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_oe   (line_oe),
    .rdy_flag  (rdy_flag),
    .perr_flag (perr_flag),
    .rdy_clr   (rdy_clr),
    .perr_clr  (perr_clr),
    .rx_data   (rx_data)
);

// File: tb/test_sc_char_rx.sv
`timescale 1ns/1ps
module test_sc_char_rx;
    localparam int ETU    = 372;
    localparam int ERRLEN = 372;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_drv = 1'b1;
    logic       line_in;
    logic       line_oe;
    logic       rx_int_en = 1'b1;
    logic       rdy_clr = 1'b0;
    logic       perr_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rdy_flag, perr_flag, irq_rx, irq_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int oe_cnt = 0;
    int oe_rise = -1;
    int start_cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign line_in = card_drv & ~line_oe;

    sc_char_rx i_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_oe(line_oe),
        .rx_int_en(rx_int_en), .rdy_clr(rdy_clr), .perr_clr(perr_clr),
        .rx_data(rx_data), .rdy_flag(rdy_flag), .perr_flag(perr_flag),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    always @(negedge clk) begin
        if (line_oe) begin
            if (oe_cnt == 0) oe_rise = cyc;
            oe_cnt++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(logic [7:0] d, logic p);
        @(negedge clk);
        oe_cnt = 0;
        oe_rise = -1;
        start_cyc = cyc;
        card_drv = 1'b0;
        repeat (ETU) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            card_drv = d[i];
            repeat (ETU) @(negedge clk);
        end
        card_drv = p;
        repeat (ETU) @(negedge clk);
        card_drv = 1'b1;
        repeat (1000) @(negedge clk);
    endtask

    task automatic pulse_clear(bit which_rdy);
        @(negedge clk);
        if (which_rdy) rdy_clr = 1'b1; else perr_clr = 1'b1;
        @(negedge clk);
        rdy_clr = 1'b0;
        perr_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "line_oe", line_oe, 0);
        chk("R1", "rdy_flag", rdy_flag, 0);
        chk("R1", "perr_flag", perr_flag, 0);
        chk("R1", "irq_rx", irq_rx, 0);
        chk("R1", "irq_err", irq_err, 0);
        chk("R1", "rx_data", rx_data, 0);
    endtask

    task automatic t_good;
        send_frame(8'hA5, ^8'hA5);
        chk("R4", "rdy_flag", rdy_flag, 1);
        chk("R4", "rx_data", rx_data, 'hA5);
        chk("R4", "perr_flag", perr_flag, 0);
        chk("R7", "oe cycles", oe_cnt, 0);
        chk("R8", "irq_rx", irq_rx, 1);
        chk("R8", "irq_err", irq_err, 0);
        pulse_clear(1);
        chk("R9", "rdy after clear", rdy_flag, 0);
        chk("R9", "irq_rx after clear", irq_rx, 0);
    endtask

    task automatic t_lsb_first;
        rx_int_en = 1'b0;
        send_frame(8'h01, 1'b1);
        chk("R3", "rx_data lsb first", rx_data, 'h01);
        chk("R3", "rdy_flag", rdy_flag, 1);
        chk("R8", "irq_rx disabled", irq_rx, 0);
        pulse_clear(1);
        send_frame(8'h80, 1'b1);
        chk("R3", "rx_data msb last", rx_data, 'h80);
        pulse_clear(1);
        rx_int_en = 1'b1;
    endtask

    task automatic t_bad_parity;
        send_frame(8'h3C, 1'b1);
        chk("R5", "perr_flag", perr_flag, 1);
        chk("R5", "rdy_flag", rdy_flag, 0);
        chk("R5", "rx_data kept", rx_data, 'h80);
        chk("R8", "irq_err", irq_err, 1);
        chk("R6", "oe onset cycle", oe_rise, start_cyc + 1 + ETU / 2 + 10 * ETU);
        chk("R6", "oe length", oe_cnt, ERRLEN);
        pulse_clear(0);
        chk("R9", "perr after clear", perr_flag, 0);
    endtask

    task automatic t_glitch;
        @(negedge clk);
        oe_cnt = 0;
        card_drv = 1'b0;
        repeat (50) @(negedge clk);
        card_drv = 1'b1;
        repeat (3 * ETU) @(negedge clk);
        chk("R2", "rdy after glitch", rdy_flag, 0);
        chk("R2", "perr after glitch", perr_flag, 0);
        chk("R2", "oe after glitch", oe_cnt, 0);
    endtask

    task automatic t_recover;
        send_frame(8'h6E, 1'b0);
        chk("R5", "perr second bad", perr_flag, 1);
        pulse_clear(0);
        send_frame(8'hFF, 1'b0);
        chk("R10", "rdy after error frame", rdy_flag, 1);
        chk("R10", "rx_data after error frame", rx_data, 'hFF);
        chk("R10", "oe for good frame", oe_cnt, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_good();
        t_lsb_first();
        t_bad_parity();
        t_glitch();
        t_recover();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule